// File: doc/BRIEF.md
# Dual-Line Serial Input Frame Merger

This block receives the input frames of a codec serial link that has two data-in lines, a primary and a secondary, both framed by one shared sync signal. Each frame is 256 bits: a 16-bit header slot followed by twelve 20-bit data slots. The header carries a codec-ready flag in its first bit, then twelve tag bits that mark which of the data slots hold data on that line.

The receiver deserializes both lines side by side and merges them at slot boundaries. Each data slot is taken from the line that tags it, and only tagged slots are presented. The lines are expected to tag disjoint slots. If both tag the same slot, the primary line wins and a sticky conflict flag is raised. Each line's codec-ready flag is held in a register that software can poll, refreshed once per frame.

The block runs on a single clock whose rising edge stands for the falling edge of the link's bit clock. The integration supplies the inverted bit clock. Every input is sampled once per clock, and one clock is one bit time.

Top module: `aclink_in_merge`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `slot_vld`, `ready_pri`, `ready_sec` and `conflict` are 0.
- R2: A frame starts at the clock edge where `sync` is seen high after having been low. That edge samples no frame bit. Frame bit 0 is sampled on the next edge. Holding `sync` high does not restart the frame.
- R3: Frame bit 0 of each line is that line's codec-ready flag. `ready_pri` and `ready_sec` take the new value in the cycle after the edge that samples frame bit 15.
- R4: The ready outputs change only at that point in each frame. At all other times they hold their value, including during frames that are cut short before bit 15.
- R5: Frame bits 1 to 12 of a line are its tags for data slots 1 to 12, in that order. Frame bits 13 to 15 are ignored. Data slot k occupies frame bits 20k-4 to 20k+15, sent MSB first.
- R6: When exactly one line tags slot k, `slot_vld` is 1 for a single cycle, in the cycle after the edge that samples that slot's 20th bit. During that cycle `slot_num` equals k and `slot_data` holds that line's 20 bits, MSB-justified.
- R7: A slot that neither line tags produces no `slot_vld` pulse. At every other time `slot_vld` is 0.
- R8: When both lines tag the same slot, the primary line's data is presented. `conflict` becomes 1 in that same cycle and stays 1 until reset.
- R9: A rising `sync` during a frame abandons that frame and starts a new one. After the edge that samples the last bit of slot 12, the line inputs are ignored until the next rising `sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Inverted bit clock; each rising edge samples one bit |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Frame sync shared by both lines |
| sdi_pri | input | 1 | Primary serial data-in line |
| sdi_sec | input | 1 | Secondary serial data-in line |
| slot_data | output | 20 | Merged slot data, MSB first on the line |
| slot_num | output | 4 | Index (1 to 12) of the presented slot |
| slot_vld | output | 1 | One-cycle strobe for a presented slot |
| ready_pri | output | 1 | Codec-ready flag of the primary line |
| ready_sec | output | 1 | Codec-ready flag of the secondary line |
| conflict | output | 1 | Sticky flag: both lines tagged one slot |

## Verification
The assertions assume that `sync` rises no more often than once per frame in normal operation. They also assume that `sync` is low when reset is released, so no frame starts unintentionally on the first cycle. The stimulus lowers `sync` at least one cycle before every rise, and it keeps `sync` low throughout reset. Every strobe is therefore separated from the next by at least twenty cycles, and a single-cycle pulse check is valid. Tag patterns cover disjoint, one-sided, empty, interleaved and overlapping cases. The overlapping case comes last among the vectors, because the conflict flag only clears on reset.

// File: rtl/aclink_in_pkg.sv
package aclink_in_pkg;
    localparam int SLOT_W     = 20;
    localparam int HDR_W      = 16;
    localparam int NUM_SLOTS  = 12;
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS + 1);
    localparam int BIT_IDX_W  = $clog2(SLOT_W);

    typedef logic [SLOT_W-1:0]     slot_word_t;
    typedef logic [SLOT_IDX_W-1:0] slot_idx_t;
    typedef logic [BIT_IDX_W-1:0]  bit_idx_t;

    typedef struct packed {
        logic                 ready;
        logic [NUM_SLOTS-1:0] tags;   // tags[i] belongs to slot i+1
    } line_hdr_t;

    typedef struct packed {
        logic       vld;
        slot_idx_t  num;
        slot_word_t data;
        logic       clash;
    } merged_t;

    function automatic line_hdr_t decode_hdr(input logic [HDR_W-1:0] w);
        line_hdr_t h;
        h.ready = w[HDR_W-1];
        for (int i = 0; i < NUM_SLOTS; i++) begin
            h.tags[i] = w[HDR_W-2-i];
        end
        return h;
    endfunction

    function automatic merged_t pick_slot(input slot_idx_t num, input logic tag_p,
                                          input logic tag_s, input slot_word_t wp,
                                          input slot_word_t ws);
        merged_t r;
        r.vld   = tag_p | tag_s;
        r.num   = num;
        r.data  = tag_p ? wp : ws;
        r.clash = tag_p & tag_s;
        return r;
    endfunction
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer
    import aclink_in_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync,
    output logic      sample_en,
    output logic      hdr_load,
    output logic      slot_last,
    output slot_idx_t slot_idx
);
    logic     sync_d;
    logic     active;
    logic     rise;
    bit_idx_t bit_idx;

    assign rise      = sync & ~sync_d;
    assign sample_en = active & ~rise;
    assign hdr_load  = sample_en && (slot_idx == '0) &&
                       (bit_idx == BIT_IDX_W'(HDR_W - 1));
    assign slot_last = sample_en && (slot_idx != '0) &&
                       (bit_idx == BIT_IDX_W'(SLOT_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_d   <= 1'b0;
            active   <= 1'b0;
            bit_idx  <= '0;
            slot_idx <= '0;
        end else begin
            sync_d <= sync;
            if (rise) begin
                active   <= 1'b1;
                bit_idx  <= '0;
                slot_idx <= '0;
            end else if (sample_en) begin
                if (hdr_load) begin
                    slot_idx <= SLOT_IDX_W'(1);
                    bit_idx  <= '0;
                end else if (slot_last) begin
                    bit_idx <= '0;
                    if (slot_idx == SLOT_IDX_W'(NUM_SLOTS)) begin
                        active <= 1'b0;
                    end else begin
                        slot_idx <= slot_idx + SLOT_IDX_W'(1);
                    end
                end else begin
                    bit_idx <= bit_idx + BIT_IDX_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/aclink_line_deser.sv
module aclink_line_deser
    import aclink_in_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_en,
    input  logic       hdr_load,
    input  logic       sdi,
    output slot_word_t word,
    output line_hdr_t  hdr
);
    logic [SLOT_W-2:0] sh;

    assign word = {sh, sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            hdr <= '0;
        end else begin
            if (sample_en) begin
                sh <= word[SLOT_W-2:0];
            end
            if (hdr_load) begin
                hdr <= decode_hdr(word[HDR_W-1:0]);
            end
        end
    end
endmodule

// File: rtl/aclink_slot_merge.sv
module aclink_slot_merge
    import aclink_in_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       slot_last,
    input  slot_idx_t  slot_idx,
    input  slot_word_t word_p,
    input  slot_word_t word_s,
    input  line_hdr_t  hdr_p,
    input  line_hdr_t  hdr_s,
    output merged_t    out_q,
    output logic       conflict_q
);
    slot_idx_t pos;
    merged_t   cand;

    assign pos  = slot_idx - SLOT_IDX_W'(1);
    assign cand = pick_slot(slot_idx, hdr_p.tags[pos], hdr_s.tags[pos], word_p, word_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q      <= '0;
            conflict_q <= 1'b0;
        end else begin
            if (slot_last) begin
                out_q      <= cand;
                conflict_q <= conflict_q | cand.clash;
            end else begin
                out_q.vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/aclink_in_merge.sv
module aclink_in_merge
    import aclink_in_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync,
    input  logic              sdi_pri,
    input  logic              sdi_sec,
    output logic [SLOT_W-1:0] slot_data,
    output logic [SLOT_IDX_W-1:0] slot_num,
    output logic              slot_vld,
    output logic              ready_pri,
    output logic              ready_sec,
    output logic              conflict
);
    localparam int NUM_LINES = 2;

    logic       sample_en;
    logic       hdr_load;
    logic       slot_last;
    slot_idx_t  slot_idx;
    slot_word_t words [NUM_LINES];
    line_hdr_t  hdrs  [NUM_LINES];
    logic       sdis  [NUM_LINES];
    merged_t    out_q;

    assign sdis[0] = sdi_pri;
    assign sdis[1] = sdi_sec;

    aclink_frame_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .sync      (sync),
        .sample_en (sample_en),
        .hdr_load  (hdr_load),
        .slot_last (slot_last),
        .slot_idx  (slot_idx)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        aclink_line_deser u_deser (
            .clk       (clk),
            .rst       (rst),
            .sample_en (sample_en),
            .hdr_load  (hdr_load),
            .sdi       (sdis[g]),
            .word      (words[g]),
            .hdr       (hdrs[g])
        );
    end

    aclink_slot_merge u_merge (
        .clk        (clk),
        .rst        (rst),
        .slot_last  (slot_last),
        .slot_idx   (slot_idx),
        .word_p     (words[0]),
        .word_s     (words[1]),
        .hdr_p      (hdrs[0]),
        .hdr_s      (hdrs[1]),
        .out_q      (out_q),
        .conflict_q (conflict)
    );

    assign slot_data = out_q.data;
    assign slot_num  = out_q.num;
    assign slot_vld  = out_q.vld;
    assign ready_pri = hdrs[0].ready;
    assign ready_sec = hdrs[1].ready;
endmodule

// File: rtl/aclink_in_merge_chk.sv
module aclink_in_merge_chk
    import aclink_in_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      slot_vld,
    input slot_idx_t slot_num,
    input logic      ready_pri,
    input logic      ready_sec,
    input logic      conflict,
    input logic      slot_last,
    input logic      hdr_load
);
    AST_VLD_AFTER_SLOT_END: assert property (@(posedge clk) disable iff (rst)
        slot_vld |-> $past(slot_last)); // R7

    AST_VLD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        slot_vld |=> !slot_vld); // R6

    AST_SLOT_NUM_RANGE: assert property (@(posedge clk) disable iff (rst)
        slot_vld |-> (slot_num >= SLOT_IDX_W'(1) && slot_num <= SLOT_IDX_W'(NUM_SLOTS))); // R5

    AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (rst)
        conflict |=> conflict); // R8

    AST_READY_PRI_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(hdr_load) |-> $stable(ready_pri)); // R4

    AST_READY_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(hdr_load) |-> $stable(ready_sec)); // R4
endmodule

bind aclink_in_merge aclink_in_merge_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .slot_vld  (slot_vld),
    .slot_num  (slot_num),
    .ready_pri (ready_pri),
    .ready_sec (ready_sec),
    .conflict  (conflict),
    .slot_last (slot_last),
    .hdr_load  (hdr_load)
);

// File: tb/tb_aclink_in_merge.sv
`timescale 1ns/1ps
module tb_aclink_in_merge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync = 1'b0;
    logic        sdi_pri = 1'b0;
    logic        sdi_sec = 1'b0;
    logic [19:0] slot_data;
    logic [3:0]  slot_num;
    logic        slot_vld;
    logic        ready_pri;
    logic        ready_sec;
    logic        conflict;

    int  n_chk = 0;
    int  n_bad = 0;
    logic exp_rp = 1'b0;
    logic exp_rs = 1'b0;
    logic exp_cf = 1'b0;

    always #2.5 clk = ~clk;

    aclink_in_merge dut (
        .clk(clk), .rst(rst), .sync(sync), .sdi_pri(sdi_pri), .sdi_sec(sdi_sec),
        .slot_data(slot_data), .slot_num(slot_num), .slot_vld(slot_vld),
        .ready_pri(ready_pri), .ready_sec(ready_sec), .conflict(conflict)
    );

    // {ready_pri, ready_sec, tags_pri[11:0], tags_sec[11:0], seed[7:0]}
    localparam int NVEC = 6;
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 12'b000000101011, 12'b010011010100, 8'h11},
        {1'b1, 1'b0, 12'hFFF,          12'h000,          8'h22},
        {1'b0, 1'b1, 12'h000,          12'hFFF,          8'h33},
        {1'b0, 1'b0, 12'h000,          12'h000,          8'h44},
        {1'b1, 1'b1, 12'hAAA,          12'h555,          8'h55},
        {1'b1, 1'b1, 12'h004,          12'h00C,          8'h66}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [19:0] gen(input int seed, input int s, input int l);
        return 20'(seed * 40503 + s * 2713 + l * 977 + 20'h5A5A5);
    endfunction

    function automatic logic fbit(input int n, input logic rdy, input logic [11:0] tags,
                                  input int seed, input int l);
        logic [19:0] d;
        if (n == 0) return rdy;
        if (n <= 12) return tags[n-1];
        if (n < 16) return 1'b1;  // ignored header bits driven high
        d = gen(seed, (n - 16) / 20 + 1, l);
        return d[19 - (n - 16) % 20];
    endfunction

    task automatic send_frame(input logic rp, input logic rs, input logic [11:0] tp,
                              input logic [11:0] ts, input int seed, input bit hold);
        @(negedge clk);
        sync = 1'b1;
        @(negedge clk);
        if (!hold) sync = 1'b0;
        sdi_pri = fbit(0, rp, tp, seed, 0);
        sdi_sec = fbit(0, rs, ts, seed, 1);
        for (int n = 0; n < 256; n++) begin
            @(negedge clk);
            if (n == 15) begin
                exp_rp = rp;
                exp_rs = rs;
            end
            chk("R3 ready_pri", 32'(ready_pri), 32'(exp_rp));
            chk("R3 ready_sec", 32'(ready_sec), 32'(exp_rs));
            if (n >= 16 && (n - 16) % 20 == 19) begin
                int s;
                logic t_p;
                logic t_s;
                s = (n - 16) / 20 + 1;
                t_p = tp[s-1];
                t_s = ts[s-1];
                if (t_p && t_s) exp_cf = 1'b1;
                chk("R7 slot_vld", 32'(slot_vld), 32'(t_p | t_s));
                if (t_p | t_s) begin
                    chk("R6 slot_num", 32'(slot_num), 32'(s));
                    chk(t_p ? "R8 slot_data pri" : "R6 slot_data sec", 32'(slot_data),
                        32'(t_p ? gen(seed, s, 0) : gen(seed, s, 1)));
                end
                chk("R8 conflict", 32'(conflict), 32'(exp_cf));
            end else begin
                chk("R7 slot_vld idle", 32'(slot_vld), 32'd0);
            end
            if (hold && n == 4) sync = 1'b0;
            if (n < 255) begin
                sdi_pri = fbit(n + 1, rp, tp, seed, 0);
                sdi_sec = fbit(n + 1, rs, ts, seed, 1);
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 slot_vld in reset", 32'(slot_vld), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 slot_vld", 32'(slot_vld), 32'd0);
        chk("R1 ready_pri", 32'(ready_pri), 32'd0);
        chk("R1 ready_sec", 32'(ready_sec), 32'd0);
        chk("R1 conflict", 32'(conflict), 32'd0);

        // Vector table: R2 R3 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            send_frame(VEC[v][33], VEC[v][32], VEC[v][31:20], VEC[v][19:8],
                       int'(VEC[v][7:0]), 1'b0);
        end

        // R2: sync held high across the first bits does not restart
        send_frame(1'b0, 1'b1, 12'h0F0, 12'h00F, 8'h77, 1'b1);

        // R9 / R4: aborted frame before bit 15, then a fresh frame
        @(negedge clk);
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        for (int i = 0; i < 10; i++) begin
            sdi_pri = 1'b0;
            sdi_sec = 1'b0;
            @(negedge clk);
            chk("R4 ready_pri aborted frame", 32'(ready_pri), 32'(exp_rp));
            chk("R4 ready_sec aborted frame", 32'(ready_sec), 32'(exp_rs));
            chk("R9 slot_vld aborted frame", 32'(slot_vld), 32'd0);
        end
        send_frame(1'b1, 1'b0, 12'h801, 12'h010, 8'h88, 1'b0);

        // R9: inputs ignored after slot 12 without a new sync
        for (int i = 0; i < 60; i++) begin
            sdi_pri = i[0];
            sdi_sec = ~i[1];
            @(negedge clk);
            chk("R9 slot_vld idle", 32'(slot_vld), 32'd0);
            chk("R9 ready_pri idle", 32'(ready_pri), 32'(exp_rp));
            chk("R9 ready_sec idle", 32'(ready_sec), 32'(exp_rs));
        end

        // R8: conflict held, cleared only by reset (R1)
        chk("R8 conflict sticky", 32'(conflict), 32'd1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 conflict after reset", 32'(conflict), 32'd0);
        chk("R1 ready_pri after reset", 32'(ready_pri), 32'd0);
        chk("R1 slot_vld after reset", 32'(slot_vld), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule